// File: doc/BRIEF.md
# E1 Per-Time-Slot Channel Processor

This block processes the 32 byte-wide time slots of an E1 frame, one slot per cycle that `slot_vld_i` is high. An internal slot counter walks the slots in order 0 to 31 and wraps. Each wrap advances a 3-bit frame counter. Each slot has an 8-bit control word in a 32-entry register file. That word decides how the slot's byte is treated on the way to the line (transmit) and on the way to the system side (receive).

On transmit, a slot can carry system data or a message byte, can have its even bits inverted, can carry the received line byte back out (remote loopback), or can carry a test signal. On receive, a slot can take the transmitted byte instead of the line byte (local loopback). It can also be overwritten with a test tone, or fed to a self-synchronising PRBS checker.

One global input picks the test source: a digital milliwatt tone or a 2^15-1 PRBS. Results are registered and appear one cycle after the slot is presented.

Top module: `e1_slot_proc`

## Requirements
- R1: After reset, all control words are 0, the slot and frame counters are 0, and `out_vld_o`, `line_tx_o`, `sys_rx_o`, `prbs_err_o` and `slot_o` are 0.
- R2: Each cycle with `slot_vld_i` high processes the current slot and then advances the slot counter (31 wraps to 0). On the next edge the block registers `out_vld_o`=1, `slot_o`=processed slot, and that slot's results. Otherwise `out_vld_o` and `prbs_err_o` go to 0.
- R3: A write with `cfg_we_i` stores `cfg_wdata_i` as a control word. `cfg_addr_i[4]` picks the bank (0: slots 0-15, 1: slots 16-31) and `cfg_addr_i[3:0]` picks the slot within the bank. The new word applies to slots processed after the write cycle.
- R4: Control bit 7 set selects `msg_i` in place of `sys_tx_i` as the slot's transmit data.
- R5: Control bit 6 set XORs the selected transmit data with 8'h55, inverting bits 0, 2, 4 and 6.
- R6: Control bit 5 set, with bit 3 clear, sends `line_rx_i` out on `line_tx_o`. The received byte still reaches `sys_rx_o` unless R7 or R11 replaces it.
- R7: Control bit 4 set makes the receive path byte equal the byte sent on `line_tx_o` instead of `line_rx_i`. `line_tx_o` is unchanged.
- R8: Control bit 3 set replaces the transmit byte with the test byte, overriding bits 7, 6 and 5. With `test_src_i`=1 the test byte is the tone; with 0 it is the PRBS.
- R9: The tone byte is selected by the frame counter from the sequence 34,21,21,34,B4,A1,A1,B4 (hex).
- R10: The PRBS generator state starts at 15'h7FFF. Each bit is b=s[14]^s[13], after which s={s[13:0],b}. Eight bits form a byte, MSB first. The generator advances only for slots with bit 3 set and `test_src_i`=0, and one generator serves all such slots in slot order.
- R11: Control bit 2 set with `test_src_i`=1 puts the tone on `sys_rx_o`. With `test_src_i`=0 it feeds the receive path byte to the checker and leaves `sys_rx_o` equal to the receive path byte.
- R12: The checker state starts at 15'h7FFF. For each received bit x (MSB first), the predicted bit is p=r[14]^r[13], `prbs_err_o` marks x^p in that bit position, and then r={r[13:0],x}. `prbs_err_o` is 0 for slots not checked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_addr_i | input | 5 | Control word address: bank bit and entry |
| cfg_wdata_i | input | 8 | Control word write data |
| test_src_i | input | 1 | Global test source: 1 tone, 0 PRBS |
| slot_vld_i | input | 1 | A slot's bytes are present this cycle |
| sys_tx_i | input | 8 | System-side transmit byte |
| msg_i | input | 8 | Message buffer byte for the current slot |
| line_rx_i | input | 8 | Byte received from the line |
| out_vld_o | output | 1 | Registered results are valid |
| slot_o | output | 5 | Slot index of the registered results |
| line_tx_o | output | 8 | Byte sent to the line |
| sys_rx_o | output | 8 | Byte delivered to the system side |
| prbs_err_o | output | 8 | Per-bit PRBS mismatch strobes |

## Verification
The bench sweeps all sixteen combinations of control bits 7 to 4 over both banks. A design that applied inversion before the message select, let remote loopback swallow the system byte, or dropped the looped byte on the system side would mismatch across whole banks.

The tone is run over nine frames, so an off-by-one in the frame index or a missed wrap shows up as a shifted byte. PRBS slots are interleaved with idle slots: a generator that advanced in every slot, or kept one generator per slot, gives the wrong bytes.

The checker is driven first through local loopback, where it must settle to zero errors. It is then driven with a stream containing one flipped bit, which must flag the flip and its two echoes 14 and 15 bits later.

// File: rtl/e1_slot_pkg.sv
package e1_slot_pkg;
  localparam int SLOTS  = 32;
  localparam int BYTE_W = 8;
  localparam int LFSR_W = 15;
  localparam int TONE_LEN = 8;
  localparam logic [BYTE_W-1:0] ADI_MASK = 8'h55;

  typedef enum logic [2:0] {
    CB_LTEST = 3'd2,
    CB_TTEST = 3'd3,
    CB_LLOOP = 3'd4,
    CB_RLOOP = 3'd5,
    CB_ADI   = 3'd6,
    CB_MSG   = 3'd7
  } ctrl_bit_e;

  function automatic logic [BYTE_W-1:0] tone_byte(input logic [2:0] idx);
    logic [BYTE_W-1:0] half;
    case (idx[1:0])
      2'd0, 2'd3: half = 8'h34;
      default:    half = 8'h21;
    endcase
    return {idx[2], half[6:0]};
  endfunction
endpackage

// File: rtl/e1_ctrl_rf.sv
module e1_ctrl_rf
  import e1_slot_pkg::*;
#(
  parameter int NSLOT = SLOTS,
  parameter int W     = BYTE_W,
  localparam int AW   = $clog2(NSLOT),
  localparam int BANK = NSLOT / 2,
  localparam int BW   = $clog2(BANK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [1:0][W-1:0] bank_rd;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [BANK-1:0][W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '0;
      else if (we_i && (waddr_i[AW-1] == 1'(b))) word_q[waddr_i[BW-1:0]] <= wdata_i;
    end
    assign bank_rd[b] = word_q[raddr_i[BW-1:0]];
  end

  assign rdata_o = bank_rd[raddr_i[AW-1]];
endmodule

// File: rtl/e1_prbs_gen.sv
module e1_prbs_gen
  import e1_slot_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int LW = LFSR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] byte_o
);
  logic [LW-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    byte_o = '0;
    for (int i = 0; i < W; i++) begin
      byte_o[W-1-i] = st_d[LW-1] ^ st_d[LW-2];
      st_d = {st_d[LW-2:0], byte_o[W-1-i]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '1;
    else if (adv_i) st_q <= st_d;
  end

  a_r10_gen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(st_q));
  a_r10_gen_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
endmodule

// File: rtl/e1_prbs_chk.sv
module e1_prbs_chk
  import e1_slot_pkg::*;
#(
  parameter int W  = BYTE_W,
  parameter int LW = LFSR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] err_o
);
  logic [LW-1:0] r_q, r_d;

  always_comb begin
    r_d = r_q;
    err_o = '0;
    for (int i = 0; i < W; i++) begin
      err_o[W-1-i] = byte_i[W-1-i] ^ r_d[LW-1] ^ r_d[LW-2];
      r_d = {r_d[LW-2:0], byte_i[W-1-i]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r_q <= '1;
    else if (en_i) r_q <= r_d;
  end

  a_r12_chk_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(r_q));
endmodule

// File: rtl/e1_slot_proc.sv
module e1_slot_proc
  import e1_slot_pkg::*;
#(
  parameter int NSLOT = SLOTS,
  parameter int W     = BYTE_W,
  localparam int AW   = $clog2(NSLOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [W-1:0]  cfg_wdata_i,
  input  logic          test_src_i,
  input  logic          slot_vld_i,
  input  logic [W-1:0]  sys_tx_i,
  input  logic [W-1:0]  msg_i,
  input  logic [W-1:0]  line_rx_i,
  output logic          out_vld_o,
  output logic [AW-1:0] slot_o,
  output logic [W-1:0]  line_tx_o,
  output logic [W-1:0]  sys_rx_o,
  output logic [W-1:0]  prbs_err_o
);
  logic [AW-1:0] slot_q;
  logic [2:0]    frame_q;
  logic [W-1:0]  ctrl, tone, prbs_byte, chk_err;
  logic [W-1:0]  sel_byte, adi_byte, tx_byte, rx_path, sys_byte;
  logic          gen_adv, chk_en;

  e1_ctrl_rf #(.NSLOT(NSLOT), .W(W)) u_rf (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .waddr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .raddr_i(slot_q), .rdata_o(ctrl)
  );

  assign gen_adv = slot_vld_i & ctrl[CB_TTEST] & ~test_src_i;
  assign chk_en  = slot_vld_i & ctrl[CB_LTEST] & ~test_src_i;

  e1_prbs_gen #(.W(W)) u_gen (
    .clk_i, .rst_ni, .adv_i(gen_adv), .byte_o(prbs_byte)
  );

  e1_prbs_chk #(.W(W)) u_chk (
    .clk_i, .rst_ni, .en_i(chk_en), .byte_i(rx_path), .err_o(chk_err)
  );

  assign tone = W'(tone_byte(frame_q));

  always_comb begin
    sel_byte = ctrl[CB_MSG] ? msg_i : sys_tx_i;
    adi_byte = ctrl[CB_ADI] ? (sel_byte ^ W'(ADI_MASK)) : sel_byte;
    if (ctrl[CB_TTEST])      tx_byte = test_src_i ? tone : prbs_byte;
    else if (ctrl[CB_RLOOP]) tx_byte = line_rx_i;
    else                     tx_byte = adi_byte;
    rx_path  = ctrl[CB_LLOOP] ? tx_byte : line_rx_i;
    sys_byte = (ctrl[CB_LTEST] && test_src_i) ? tone : rx_path;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      frame_q <= '0;
    end else if (slot_vld_i) begin
      if (slot_q == AW'(NSLOT-1)) begin
        slot_q  <= '0;
        frame_q <= frame_q + 3'd1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o  <= 1'b0;
      slot_o     <= '0;
      line_tx_o  <= '0;
      sys_rx_o   <= '0;
      prbs_err_o <= '0;
    end else begin
      out_vld_o  <= slot_vld_i;
      prbs_err_o <= chk_en ? chk_err : '0;
      if (slot_vld_i) begin
        slot_o    <= slot_q;
        line_tx_o <= tx_byte;
        sys_rx_o  <= sys_byte;
      end
    end
  end

  a_r2_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_vld_i |=> out_vld_o);
  a_r2_slot_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_i && out_vld_o) |=>
      (slot_o == (($past(slot_o) == AW'(NSLOT-1)) ? '0 : $past(slot_o) + 1'b1)));
  a_r12_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> (prbs_err_o == '0));
  a_r7_local_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_i && ctrl[CB_LLOOP] && !ctrl[CB_LTEST]) |=> (sys_rx_o == line_tx_o));
endmodule

// File: tb/e1_slot_proc_tb.sv
module e1_slot_proc_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       test_src = 1'b0;
  logic       slot_vld = 1'b0;
  logic [7:0] sys_tx = '0, msg = '0, line_rx = '0;
  logic       out_vld;
  logic [4:0] slot_out;
  logic [7:0] line_tx, sys_rx, prbs_err;

  int n_cmp = 0, n_bad = 0;
  logic [7:0]  m_ctrl [32];
  int          m_slot = 0, m_frame = 0;
  logic [14:0] m_gen = 15'h7fff, m_chk = 15'h7fff, m_src = 15'h1234;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_slot_proc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .test_src_i(test_src), .slot_vld_i(slot_vld),
    .sys_tx_i(sys_tx), .msg_i(msg), .line_rx_i(line_rx),
    .out_vld_o(out_vld), .slot_o(slot_out), .line_tx_o(line_tx),
    .sys_rx_o(sys_rx), .prbs_err_o(prbs_err)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s slot %0d frame %0d: got %h expected %h", tag, m_slot, m_frame, got, exp);
    end
  endtask

  function automatic logic [7:0] tone_of(input int f);
    logic [7:0] t [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};
    return t[f % 8];
  endfunction

  function automatic logic [7:0] lfsr_byte(input logic [14:0] s);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      b[i] = s[14] ^ s[13];
      s = {s[13:0], b[i]};
    end
    return b;
  endfunction

  function automatic logic [7:0] chk_mask(input logic [14:0] r, input logic [7:0] x);
    logic [7:0] e;
    for (int i = 7; i >= 0; i--) begin
      e[i] = x[i] ^ r[14] ^ r[13];
      r = {r[13:0], x[i]};
    end
    return e;
  endfunction

  task automatic wr_ctrl(input int s, input logic [7:0] v);
    @(negedge clk);
    slot_vld = 1'b0;
    cfg_we = 1'b1; cfg_addr = 5'(s); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_ctrl[s] = v;
  endtask

  task automatic clear_ctrl();
    for (int s = 0; s < 32; s++) wr_ctrl(s, 8'h00);
  endtask

  task automatic do_slot(input logic [7:0] st, input logic [7:0] mg, input logic [7:0] rx);
    logic [7:0] c, sel, txb, rxp, sysb, tn, pb, em;
    bit chk;
    @(negedge clk);
    slot_vld = 1'b1; sys_tx = st; msg = mg; line_rx = rx;
    c  = m_ctrl[m_slot];
    tn = tone_of(m_frame);
    pb = lfsr_byte(m_gen);
    sel = c[7] ? mg : st;
    if (c[6]) sel = sel ^ 8'h55;
    txb = c[3] ? (test_src ? tn : pb) : (c[5] ? rx : sel);
    rxp = c[4] ? txb : rx;
    sysb = (c[2] && test_src) ? tn : rxp;
    chk = c[2] && !test_src;
    em = chk ? chk_mask(m_chk, rxp) : 8'h00;
    @(posedge clk);
    #1;
    check("R2 valid", {31'd0, out_vld}, 32'd1);
    check("R2 slot", {27'd0, slot_out}, 32'(m_slot));
    check("R4/R5/R6/R8 line byte", {24'd0, line_tx}, {24'd0, txb});
    check("R6/R7/R11 system byte", {24'd0, sys_rx}, {24'd0, sysb});
    check("R12 error mask", {24'd0, prbs_err}, {24'd0, em});
    if (c[3] && !test_src) m_gen = {m_gen[6:0], pb};
    if (chk) m_chk = {m_chk[6:0], rxp};
    if (m_slot == 31) begin m_slot = 0; m_frame++; end
    else m_slot++;
  endtask

  task automatic idle();
    @(negedge clk);
    slot_vld = 1'b0;
    @(posedge clk);
    #1;
    check("R2 idle valid", {31'd0, out_vld}, 32'd0);
    check("R12 idle mask", {24'd0, prbs_err}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rxb;
    for (int s = 0; s < 32; s++) m_ctrl[s] = 8'h00;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset valid", {31'd0, out_vld}, 32'd0);
    check("R1 reset line", {24'd0, line_tx}, 32'd0);
    check("R1 reset sys", {24'd0, sys_rx}, 32'd0);
    check("R1 reset mask", {24'd0, prbs_err}, 32'd0);
    check("R1 reset slot", {27'd0, slot_out}, 32'd0);

    // R1: plain pass-through with reset control words
    for (int s = 0; s < 32; s++) do_slot(8'(s * 5 + 1), 8'hEE, 8'(s * 3 + 7));
    idle();

    // R3 R4 R5 R6 R7: all combos of bits 7..4 in both banks
    for (int s = 0; s < 32; s++) wr_ctrl(s, {4'(s), 4'h0});
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 32; s++)
        do_slot(8'(s * 7 + f), 8'(~(s * 11)), 8'(s * 13 + f * 3 + 1));
    idle();

    // R3: bank bit picks slot 16, not slot 0
    wr_ctrl(16, 8'h80);
    for (int s = 0; s < 32; s++) do_slot(8'(s + 40), 8'(s + 90), 8'(s + 200));

    // R8 R9 R11: tone on line and system side
    clear_ctrl();
    test_src = 1'b1;
    wr_ctrl(3, 8'h0C);
    wr_ctrl(30, 8'h04);
    wr_ctrl(12, 8'h08);
    for (int f = 0; f < 9; f++)
      for (int s = 0; s < 32; s++) do_slot(8'(s), 8'(f), 8'(s ^ 8'h5A));

    // R10: shared generator in slot order, idle slots between
    clear_ctrl();
    test_src = 1'b0;
    wr_ctrl(5, 8'h08);
    wr_ctrl(20, 8'hE8);
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < 32; s++) do_slot(8'(s), 8'(s + 1), 8'(s + 2));

    // R7 R11 R12: generator looped locally into checker
    clear_ctrl();
    wr_ctrl(9, 8'h1C);
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < 32; s++) begin
        do_slot(8'(s), 8'h00, 8'hFF);
        if (s == 9 && f >= 2) check("R12 settled loop", {24'd0, prbs_err}, 32'd0);
      end

    // R12: external stream with one flipped bit
    clear_ctrl();
    wr_ctrl(9, 8'h04);
    for (int f = 0; f < 6; f++)
      for (int s = 0; s < 32; s++) begin
        rxb = 8'(s);
        if (s == 9) begin
          rxb = lfsr_byte(m_src);
          m_src = {m_src[6:0], rxb};
          if (f == 3) rxb = rxb ^ 8'h10;
        end
        do_slot(8'h11, 8'h22, rxb);
        if (s == 9 && f == 3) check("R12 flip flagged", {31'd0, prbs_err != 0}, 32'd1);
      end
    idle();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule